// File: doc/BRIEF.md
# Caller Number Frame Parser

This block sits behind a byte-level asynchronous receiver on a subscriber line and turns its byte stream into checked message records. It first waits for a run of alternating-bit bytes (0x55) that announces an incoming message. It then treats the next byte that differs from 0x55 as the message type, reads a byte count, passes the payload on byte by byte and closes the frame on a modulo-256 checksum byte.

Two payload layouts are handled. In the plain layout the payload is one field of at most a few characters, such as date, time and calling digits. In the parameterised layout the payload is a chain of sub-records. Each sub-record starts with a tag byte and a count byte, followed by that many bytes. Every payload byte leaves the block tagged with its field code and marked as the first and/or last byte of its field. A one-cycle completion strobe reports a good checksum, a length fault or an idle-gap abort.

Top module: `cid_frame_checker`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_vld, out_first, out_last, frame_done, cksum_ok, len_err and tmo_err are all 0.
- R2: A message type is accepted only after at least MIN_SEIZE consecutive 0x55 bytes. A shorter run, or a run broken by any other byte, makes the block ignore the bytes that follow, with no data output and no frame_done, until a full run is seen. Further 0x55 bytes after a full run are absorbed.
- R3: A type byte with bit 7 clear selects the plain layout. Each payload byte appears on out_data with out_vld high on the cycle after it is received. out_type equals the message type, out_first is set on the first payload byte only, and out_last on the final one only.
- R4: A type byte with bit 7 set selects the parameterised layout. The payload is read as repeated tag byte, count byte, then count data bytes. Only the data bytes are output, each with out_type equal to its tag, and with out_first and out_last marking the first and last data byte of that sub-record.
- R5: The byte after the payload is the checksum. On the cycle after it arrives, frame_done pulses for one cycle, and cksum_ok is 1 exactly when type, length, all payload bytes and the checksum sum to 0 modulo 256.
- R6: In the plain layout a length byte above MAX_SINGLE ends the frame on the next cycle with frame_done and len_err high, and no payload byte is output.
- R7: In the parameterised layout, the frame ends with frame_done and len_err high in two cases: a tag byte with fewer than two message bytes left, or a sub-record count larger than the message bytes left after the count byte.
- R8: After the type byte has been taken, GAP_BYTES*BYTE_CLKS consecutive clocks without a byte end the frame with frame_done and tmo_err high. A shorter gap has no effect.
- R9: A length byte of 0 moves directly to the checksum byte, with no payload output.
- R10: cksum_ok, len_err and tmo_err are never high without frame_done, at most one of them is high at a time, and out_vld is never high together with frame_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Received byte strobe, one cycle per byte |
| byte_data | input | 8 | Received byte |
| out_vld | output | 1 | Payload byte valid |
| out_data | output | 8 | Payload byte |
| out_type | output | 8 | Field code: message type (plain) or sub-record tag (parameterised) |
| out_first | output | 1 | First byte of its field |
| out_last | output | 1 | Last byte of its field |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| cksum_ok | output | 1 | Checksum closed to zero (valid with frame_done) |
| len_err | output | 1 | Length fault abort (valid with frame_done) |
| tmo_err | output | 1 | Idle-gap abort (valid with frame_done) |

## Verification
The bench builds the block with MIN_SEIZE=10, MAX_SINGLE=18, GAP_BYTES=20 and BYTE_CLKS shortened to 4, so the idle-gap limit is 80 clocks. With that limit the bench can send a byte a few clocks before expiry and can also wait past it, all within a short run. Keeping MAX_SINGLE at 18 makes both sides of the plain-layout limit (18 accepted, 19 refused) cheap to exercise. A seizure run of exactly ten bytes, and runs of nine or broken runs, probe the acceptance threshold.

// File: rtl/cid_pkg.sv
package cid_pkg;

  typedef enum logic [2:0] {
    S_HUNT,
    S_ARMED,
    S_LEN,
    S_SDATA,
    S_PTYPE,
    S_PLEN,
    S_PDATA,
    S_CSUM
  } cid_state_e;

  localparam logic [7:0] SEIZE_BYTE = 8'h55;

  // running modulo-256 sum
  function automatic logic [7:0] csum_add(input logic [7:0] acc, input logic [7:0] b);
    return acc + b;
  endfunction

  // true when adding the final byte brings the sum to zero
  function automatic logic csum_closes(input logic [7:0] acc, input logic [7:0] b);
    return (csum_add(acc, b) == 8'h00);
  endfunction

  // bit 7 of the type byte selects the parameterised layout
  function automatic logic is_multi(input logic [7:0] t);
    return t[7];
  endfunction

endpackage

// File: rtl/cid_seize_det.sv
module cid_seize_det #(
  parameter int MIN_RUN = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hunt,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output logic       run_done
);
  import cid_pkg::*;

  localparam int CW = $clog2(MIN_RUN + 1);
  localparam logic [CW-1:0] RUN_TOP = CW'(MIN_RUN - 1);

  logic [CW-1:0] run_cnt;
  logic          is_pat;

  assign is_pat   = (byte_data == SEIZE_BYTE);
  assign run_done = hunt && byte_vld && is_pat && (run_cnt >= RUN_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!hunt) begin
      run_cnt <= '0;
    end else if (byte_vld) begin
      if (!is_pat)               run_cnt <= '0;
      else if (run_cnt < RUN_TOP) run_cnt <= run_cnt + 1'b1;
    end
  end

  // R2: counter restarts as soon as hunting stops
  p_run_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hunt |=> (run_cnt == '0));

endmodule

// File: rtl/cid_gap_timer.sv
module cid_gap_timer #(
  parameter int LIMIT = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic byte_vld,
  output logic gap_expired
);
  localparam int GW = $clog2(LIMIT + 1);
  localparam logic [GW-1:0] LAST = GW'(LIMIT - 1);

  logic [GW-1:0] gap_cnt;

  assign gap_expired = active && !byte_vld && (gap_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              gap_cnt <= '0;
    else if (!active || byte_vld || gap_expired) gap_cnt <= '0;
    else                                     gap_cnt <= gap_cnt + 1'b1;
  end

  // R8: idle count never passes the limit
  p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= LAST);

endmodule

// File: rtl/cid_sum_acc.sv
module cid_sum_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       add,
  input  logic [7:0] byte_data,
  output logic [7:0] sum
);
  import cid_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= 8'h00;
    else if (load) sum <= byte_data;
    else if (add)  sum <= csum_add(sum, byte_data);
  end

endmodule

// File: rtl/cid_frame_checker.sv
module cid_frame_checker #(
  parameter int MIN_SEIZE  = 10,
  parameter int MAX_SINGLE = 18,
  parameter int BYTE_CLKS  = 16,
  parameter int GAP_BYTES  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  output logic       out_vld,
  output logic [7:0] out_data,
  output logic [7:0] out_type,
  output logic       out_first,
  output logic       out_last,
  output logic       frame_done,
  output logic       cksum_ok,
  output logic       len_err,
  output logic       tmo_err
);
  import cid_pkg::*;

  localparam int GAP_LIMIT = GAP_BYTES * BYTE_CLKS;
  localparam logic [7:0] SINGLE_CAP = 8'(MAX_SINGLE);

  cid_state_e state;
  logic [7:0] msg_type, par_type;
  logic [7:0] rem_msg, rem_par;
  logic       multi, lead;
  logic [7:0] sum;

  // named internal events
  logic run_done, gap_expired, active;
  logic take_type, sum_add;
  logic [7:0] rem_after;

  assign active    = (state != S_HUNT) && (state != S_ARMED);
  assign take_type = byte_vld && (state == S_ARMED) && (byte_data != SEIZE_BYTE);
  assign sum_add   = byte_vld && active && (state != S_CSUM);
  assign rem_after = rem_msg - 8'd1;

  cid_seize_det #(.MIN_RUN(MIN_SEIZE)) u_seize (
    .clk(clk), .rst_n(rst_n), .hunt(state == S_HUNT),
    .byte_vld(byte_vld), .byte_data(byte_data), .run_done(run_done)
  );

  cid_gap_timer #(.LIMIT(GAP_LIMIT)) u_gap (
    .clk(clk), .rst_n(rst_n), .active(active),
    .byte_vld(byte_vld), .gap_expired(gap_expired)
  );

  cid_sum_acc u_sum (
    .clk(clk), .rst_n(rst_n), .load(take_type), .add(sum_add),
    .byte_data(byte_data), .sum(sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_HUNT;
      msg_type   <= 8'h00;
      par_type   <= 8'h00;
      rem_msg    <= 8'h00;
      rem_par    <= 8'h00;
      multi      <= 1'b0;
      lead       <= 1'b0;
      out_vld    <= 1'b0;
      out_data   <= 8'h00;
      out_type   <= 8'h00;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      frame_done <= 1'b0;
      cksum_ok   <= 1'b0;
      len_err    <= 1'b0;
      tmo_err    <= 1'b0;
    end else begin
      out_vld    <= 1'b0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      frame_done <= 1'b0;
      cksum_ok   <= 1'b0;
      len_err    <= 1'b0;
      tmo_err    <= 1'b0;
      if (gap_expired) begin
        state      <= S_HUNT;
        frame_done <= 1'b1;
        tmo_err    <= 1'b1;
      end else if (byte_vld) begin
        unique case (state)
          S_HUNT: begin
            if (run_done) state <= S_ARMED;
          end
          S_ARMED: begin
            if (take_type) begin
              msg_type <= byte_data;
              multi    <= is_multi(byte_data);
              state    <= S_LEN;
            end
          end
          S_LEN: begin
            rem_msg <= byte_data;
            lead    <= 1'b1;
            if (!multi && (byte_data > SINGLE_CAP)) begin
              state      <= S_HUNT;
              frame_done <= 1'b1;
              len_err    <= 1'b1;
            end else if (byte_data == 8'h00) begin
              state <= S_CSUM;
            end else begin
              state <= multi ? S_PTYPE : S_SDATA;
            end
          end
          S_SDATA: begin
            out_vld   <= 1'b1;
            out_data  <= byte_data;
            out_type  <= msg_type;
            out_first <= lead;
            out_last  <= (rem_msg == 8'd1);
            lead      <= 1'b0;
            rem_msg   <= rem_after;
            if (rem_msg == 8'd1) state <= S_CSUM;
          end
          S_PTYPE: begin
            if (rem_msg < 8'd2) begin
              state      <= S_HUNT;
              frame_done <= 1'b1;
              len_err    <= 1'b1;
            end else begin
              par_type <= byte_data;
              rem_msg  <= rem_after;
              state    <= S_PLEN;
            end
          end
          S_PLEN: begin
            if (byte_data > rem_after) begin
              state      <= S_HUNT;
              frame_done <= 1'b1;
              len_err    <= 1'b1;
            end else begin
              rem_msg <= rem_after;
              rem_par <= byte_data;
              lead    <= 1'b1;
              if (byte_data != 8'h00)      state <= S_PDATA;
              else if (rem_after == 8'h00) state <= S_CSUM;
              else                         state <= S_PTYPE;
            end
          end
          S_PDATA: begin
            out_vld   <= 1'b1;
            out_data  <= byte_data;
            out_type  <= par_type;
            out_first <= lead;
            out_last  <= (rem_par == 8'd1);
            lead      <= 1'b0;
            rem_par   <= rem_par - 8'd1;
            rem_msg   <= rem_after;
            if (rem_par == 8'd1) state <= (rem_msg == 8'd1) ? S_CSUM : S_PTYPE;
          end
          S_CSUM: begin
            state      <= S_HUNT;
            frame_done <= 1'b1;
            cksum_ok   <= csum_closes(sum, byte_data);
          end
          default: state <= S_HUNT;
        endcase
      end
    end
  end

  // R10: status flags only ride on the completion strobe
  p_flag_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cksum_ok || len_err || tmo_err) |-> frame_done);

  // R10: never two outcomes at once
  p_one_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cksum_ok, len_err, tmo_err}));

  // R10: payload and completion never share a cycle
  p_no_out_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_vld && frame_done));

  // R3: every payload byte is caused by a received byte
  p_out_from_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(byte_vld));

  // R2: leaving the hunt needs a complete seizure run
  p_arm_needs_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ARMED && $past(state) == S_HUNT) |-> $past(run_done));

  // R8: idle abort only after a cycle without a byte
  p_tmo_on_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |-> !$past(byte_vld));

  // R5: a non-timeout completion is caused by a received byte
  p_done_from_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !tmo_err) |-> $past(byte_vld));

  // R6: plain-layout length fault only for an oversize count
  p_single_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (len_err && $past(state) == S_LEN) |-> ($past(byte_data) > SINGLE_CAP && !$past(multi)));

endmodule

// File: tb/tb_cid_frame_checker.sv
module tb_cid_frame_checker;

  localparam int BYTE_CLKS = 4;
  localparam int GAP_BYTES = 20;
  localparam int LIMIT     = BYTE_CLKS * GAP_BYTES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic out_vld, out_first, out_last, frame_done, cksum_ok, len_err, tmo_err;
  logic [7:0] out_data, out_type;

  always #5 clk = ~clk;

  cid_frame_checker #(.MIN_SEIZE(10), .MAX_SINGLE(18), .BYTE_CLKS(BYTE_CLKS), .GAP_BYTES(GAP_BYTES)) dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .out_vld(out_vld), .out_data(out_data), .out_type(out_type),
    .out_first(out_first), .out_last(out_last), .frame_done(frame_done),
    .cksum_ok(cksum_ok), .len_err(len_err), .tmo_err(tmo_err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // output monitor
  int n_out = 0, n_done = 0, n_clash = 0;
  logic [7:0] g_data [64];
  logic [7:0] g_type [64];
  logic       g_first [64];
  logic       g_last [64];
  logic d_ok = 0, d_len = 0, d_tmo = 0;

  always @(negedge clk) begin
    if (out_vld) begin
      g_data[n_out % 64]  = out_data;
      g_type[n_out % 64]  = out_type;
      g_first[n_out % 64] = out_first;
      g_last[n_out % 64]  = out_last;
      n_out++;
    end
    if (frame_done) begin
      n_done++;
      d_ok = cksum_ok; d_len = len_err; d_tmo = tmo_err;
    end
    if (out_vld && frame_done) n_clash++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = b;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic seize(input int n);
    for (int i = 0; i < n; i++) put(8'h55);
  endtask

  function automatic logic [7:0] neg_of(input int s);
    return 8'((256 - (s % 256)) % 256);
  endfunction

  function automatic string req_name(input int r);
    case (r)
      3: return "R3";
      5: return "R5";
      6: return "R6";
      default: return "R9";
    endcase
  endfunction

  // stimulus / expectation table (plain layout, payload byte i = 0x30+i)
  typedef struct packed {
    logic [7:0] mtype;
    logic [7:0] mlen;
    logic [7:0] nsend;
    logic [1:0] cmode;   // 0 good checksum, 1 bad checksum, 2 none
    logic       exp_ok;
    logic       exp_len;
    logic [7:0] exp_nout;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h04, 8'd3,  8'd3,  2'd0, 1'b1, 1'b0, 8'd3,  4'd3},
    '{8'h04, 8'd3,  8'd3,  2'd1, 1'b0, 1'b0, 8'd3,  4'd5},
    '{8'h04, 8'd0,  8'd0,  2'd0, 1'b1, 1'b0, 8'd0,  4'd9},
    '{8'h04, 8'd19, 8'd0,  2'd2, 1'b0, 1'b1, 8'd0,  4'd6},
    '{8'h04, 8'd18, 8'd18, 2'd0, 1'b1, 1'b0, 8'd18, 4'd6},
    '{8'h06, 8'd1,  8'd1,  2'd0, 1'b1, 1'b0, 8'd1,  4'd3}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    int b0, d0, s, bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({out_vld, out_first, out_last, frame_done, cksum_ok, len_err, tmo_err} == 7'd0,
        "R1 outputs in reset", {out_vld, frame_done, cksum_ok, len_err, tmo_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({out_vld, frame_done, cksum_ok, len_err, tmo_err} == 5'd0,
        "R1 outputs after reset", {out_vld, frame_done, cksum_ok, len_err, tmo_err}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      b0 = n_out; d0 = n_done;
      seize(12);
      put(VECS[v].mtype); put(VECS[v].mlen);
      s = VECS[v].mtype + VECS[v].mlen;
      for (int i = 0; i < VECS[v].nsend; i++) begin
        put(8'(8'h30 + i)); s += 8'h30 + i;
      end
      if (VECS[v].cmode == 2'd0) put(neg_of(s));
      if (VECS[v].cmode == 2'd1) put(8'(neg_of(s) + 8'd1));
      repeat (3) @(negedge clk);
      chk(n_done == d0 + 1, req_name(VECS[v].req), n_done - d0, 1);
      chk(d_ok == VECS[v].exp_ok, {req_name(VECS[v].req), " cksum_ok"}, d_ok, VECS[v].exp_ok);
      chk(d_len == VECS[v].exp_len, {req_name(VECS[v].req), " len_err"}, d_len, VECS[v].exp_len);
      chk(n_out - b0 == int'(VECS[v].exp_nout), {req_name(VECS[v].req), " payload count"}, n_out - b0, VECS[v].exp_nout);
      bad = 0;
      for (int i = 0; i < int'(VECS[v].exp_nout) && i < n_out - b0; i++) begin
        int k;
        k = (b0 + i) % 64;
        if (g_data[k] != 8'(8'h30 + i) || g_type[k] != VECS[v].mtype ||
            g_first[k] != (i == 0) || g_last[k] != (i == int'(VECS[v].exp_nout) - 1)) bad++;
      end
      chk(bad == 0, "R3 payload data/type/first/last", bad, 0);
    end

    // R2 short run of nine
    b0 = n_out; d0 = n_done;
    seize(9);
    put(8'h04); put(8'h03); put(8'h31); put(8'h32); put(8'h33); put(8'h00);
    repeat (3) @(negedge clk);
    chk(n_out == b0 && n_done == d0, "R2 nine-byte run ignored", n_out - b0 + n_done - d0, 0);

    // R2 broken run
    seize(5); put(8'h00); seize(5);
    put(8'h04); put(8'h01); put(8'h31); put(8'h00);
    repeat (3) @(negedge clk);
    chk(n_out == b0 && n_done == d0, "R2 broken run ignored", n_out - b0 + n_done - d0, 0);

    // R2 exactly ten, then R4 parameterised frame
    b0 = n_out; d0 = n_done;
    seize(10);
    begin
      logic [7:0] fr [9] = '{8'h80, 8'h07, 8'h01, 8'h02, 8'hAA, 8'hBB, 8'h07, 8'h01, 8'hCC};
      s = 0;
      foreach (fr[i]) begin put(fr[i]); s += fr[i]; end
      put(neg_of(s));
    end
    repeat (3) @(negedge clk);
    chk(n_done == d0 + 1 && d_ok, "R2 ten-byte run accepted, R5 good", d_ok, 1);
    chk(n_out - b0 == 3, "R4 payload count", n_out - b0, 3);
    chk(g_data[b0 % 64] == 8'hAA && g_type[b0 % 64] == 8'h01 && g_first[b0 % 64] && !g_last[b0 % 64],
        "R4 first byte of tag 01", g_type[b0 % 64], 1);
    chk(g_data[(b0 + 1) % 64] == 8'hBB && !g_first[(b0 + 1) % 64] && g_last[(b0 + 1) % 64],
        "R4 last byte of tag 01", g_data[(b0 + 1) % 64], 8'hBB);
    chk(g_data[(b0 + 2) % 64] == 8'hCC && g_type[(b0 + 2) % 64] == 8'h07 &&
        g_first[(b0 + 2) % 64] && g_last[(b0 + 2) % 64], "R4 single-byte tag 07", g_type[(b0 + 2) % 64], 7);

    // R7 count overrun
    d0 = n_done; b0 = n_out;
    seize(12); put(8'h80); put(8'h04); put(8'h01); put(8'h05);
    repeat (3) @(negedge clk);
    chk(n_done == d0 + 1 && d_len && n_out == b0, "R7 count overrun", d_len, 1);

    // R7 header overrun
    d0 = n_done;
    seize(12); put(8'h80); put(8'h01); put(8'h01);
    repeat (3) @(negedge clk);
    chk(n_done == d0 + 1 && d_len, "R7 tag with one byte left", d_len, 1);

    // R8 idle gap
    d0 = n_done;
    seize(12); put(8'h04); put(8'h05); put(8'h31);
    repeat (LIMIT - 3) @(negedge clk);
    put(8'h32);
    chk(n_done == d0, "R8 short gap harmless", n_done - d0, 0);
    repeat (LIMIT - 3) @(negedge clk);
    chk(n_done == d0, "R8 no early abort", n_done - d0, 0);
    repeat (6) @(negedge clk);
    chk(n_done == d0 + 1 && d_tmo && !d_ok, "R8 abort after gap", d_tmo, 1);

    // R10 overlap
    chk(n_clash == 0, "R10 out_vld with frame_done", n_clash, 0);

    finish_run();
  end

endmodule